// File: doc/BRIEF.md
# SMBus Word Register Slave

This block lets an external bus host read and write 16-bit registers over a two-wire SMBus link using the word write and word read transactions. It never starts a transaction. The block oversamples the clock and data lines with the fast system clock. Each line passes through a synchronizer and a glitch filter. Start and stop conditions and clock edges are then decoded from the filtered lines. The block pulls the data line low through an open-drain enable output.

The bus address is fixed at 7-bit 0x09, which is 0x12 with the direction bit clear. Command codes below `NUM_REGS` select writable registers. Two further command codes return fixed identification words. A parallel read port gives the rest of the chip direct access to the writable registers. A supply-valid input gates the whole interface: while it is low, the block ignores the bus and stays idle.

Top module: `smb_word_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x09 by driving SDA low on the ninth clock. A byte with any other address is not acknowledged, and the bytes that follow up to the next start have no effect on any register.
- R2: After reset and between transactions `sda_oe` is 0. The block drives SDA only during an acknowledge bit it gives or a data bit it returns.
- R3: In a word write (address 0x12, command, low byte, high byte), each byte is acknowledged. The register chosen by the command is updated only after the acknowledge of the high byte, and the new value then appears on `rd_data` for `rd_idx` equal to the command.
- R4: In a word read (address 0x12, command, repeated start, address 0x13), the block returns the low byte and then, if the host acknowledges, the high byte.
- R5: Command 0xFE reads 0x0040 and command 0xFF reads 0x0008. Word writes to these two commands leave the values they read back unchanged.
- R6: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high. A stop before the high byte of a write leaves the register unchanged. A repeated start restarts address reception.
- R7: Bits are taken on the rising SCL edge, most significant bit first. Bits the block returns are also sent most significant bit first.
- R8: While `supply_ok` is 0, the block gives no acknowledge and changes no register. Once `supply_ok` returns to 1, normal operation resumes at the next start.
- R9: A host NACK after a returned byte ends the transfer, and the block then releases SDA for any further clocks.
- R10: A low pulse on SCL shorter than `FILT_LEN` system clocks is ignored and does not shift a bit.
- R11: A command at or above `NUM_REGS`, other than 0xFE and 0xFF, reads 0x0000, and writes to it are ignored.
- R12: After reset every writable register reads 0x0000 on the parallel port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-valid enable; the bus is ignored while low |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rd_idx | input | IDX_W | Parallel read index of a writable register |
| rd_data | output | 16 | Contents of the indexed register (0 if out of range) |

## Verification
Random word writes and reads over all writable commands, the identification codes and an unused code are checked against a bench register model. These runs separate correct addressing, byte order and bit order from swapped or shifted data. Directed cases cover the following: a wrong address, a stop after the low byte, a write while the supply input is low, and a host NACK after the low byte followed by further clocks. Each of these separates the designed suppression from a register update or a stray SDA drive. A one-clock-short SCL glitch inside a data bit shows whether the filter keeps a spurious edge from shifting the received byte.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [6:0]  SLV_ADDR = 7'h09;
  localparam logic [7:0]  CMD_MFR  = 8'hFE;
  localparam logic [7:0]  CMD_DEV  = 8'hFF;
  localparam logic [15:0] MFR_WORD = 16'h0040;
  localparam logic [15:0] DEV_WORD = 16'h0008;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TACK} smb_st_e;
  typedef enum logic [2:0] {RB_ADDR, RB_CMD, RB_DLO, RB_DHI, RB_DONE} rx_byte_e;

  function automatic logic addr_hit(input logic [7:0] b);
    return b[7:1] == SLV_ADDR;
  endfunction

  function automatic logic is_id_cmd(input logic [7:0] c);
    return (c == CMD_MFR) || (c == CMD_DEV);
  endfunction

  function automatic logic [15:0] id_word(input logic [7:0] c);
    return (c == CMD_MFR) ? MFR_WORD : DEV_WORD;
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      flt_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == flt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q <= '0;
        flt_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = flt_q;

  // R10: the filtered line only moves after the raw level persisted
  a_r10_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_q) |-> ($past(cnt_q) == CW'(FILT_LEN - 1)));
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
  import smb_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_cmd,
  input  logic [15:0]      wr_data,
  input  logic [7:0]       bus_cmd,
  output logic [15:0]      bus_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data
);
  logic [15:0] regs_q [NREG];
  logic        wr_hit;

  assign wr_hit = wr_en && (int'(wr_cmd) < NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs_q[g] <= '0;
      else if (wr_hit && int'(wr_cmd) == g)       regs_q[g] <= wr_data;
    end
  end

  always_comb begin
    if (is_id_cmd(bus_cmd))          bus_data = id_word(bus_cmd);
    else if (int'(bus_cmd) < NREG)   bus_data = regs_q[bus_cmd[IDX_W-1:0]];
    else                             bus_data = '0;
  end

  assign rd_data = (int'(rd_idx) < NREG) ? regs_q[rd_idx] : '0;

  // R11: out-of-range or identification writes leave the indexed view unchanged
  a_r11_range_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_cmd) >= NREG) |=> $stable(rd_data) || !$stable(rd_idx));
endmodule

// File: rtl/smb_word_slave.sv
module smb_word_slave
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int FILT_LEN = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data
);
  logic scl_f, sda_f, scl_p, sda_p;
  logic start_w, stop_w, scl_rise_w, scl_fall_w;

  smb_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_flt (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
  smb_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_flt (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  // Named bus events, used by the FSM and by the assertions
  assign start_w    = scl_f && scl_p && sda_p && !sda_f;
  assign stop_w     = scl_f && scl_p && !sda_p && sda_f;
  assign scl_rise_w = scl_f && !scl_p;
  assign scl_fall_w = !scl_f && scl_p;

  smb_st_e     st_q;
  rx_byte_e    rb_q;
  logic [3:0]  bitcnt_q;
  logic [7:0]  sh_q, cmd_q, lo_q, hi_q, tx_q;
  logic        go_tx_q, tx_hi_q, mack_q, wr_en_q;
  logic [15:0] bus_val;

  smb_reg_file #(.NREG(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_q), .wr_cmd(cmd_q),
    .wr_data({hi_q, lo_q}), .bus_cmd(cmd_q), .bus_data(bus_val),
    .rd_idx(rd_idx), .rd_data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  rb_q <= RB_ADDR;  bitcnt_q <= '0;
      sh_q <= '0;  cmd_q <= '0;  lo_q <= '0;  hi_q <= '0;  tx_q <= '0;
      go_tx_q <= 1'b0;  tx_hi_q <= 1'b0;  mack_q <= 1'b0;
      wr_en_q <= 1'b0;  sda_oe <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (!supply_ok || stop_w) begin
        st_q   <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_w) begin
        st_q     <= ST_RX;
        rb_q     <= RB_ADDR;
        bitcnt_q <= '0;
        sda_oe   <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_w) begin
              sh_q     <= {sh_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall_w && bitcnt_q == 4'd8) begin
              st_q   <= ST_ACK;
              sda_oe <= 1'b1;
              unique case (rb_q)
                RB_ADDR: begin
                  go_tx_q <= sh_q[0];
                  rb_q    <= RB_CMD;
                  if (!addr_hit(sh_q)) begin
                    st_q   <= ST_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
                RB_CMD:  begin cmd_q <= sh_q; rb_q <= RB_DLO; end
                RB_DLO:  begin lo_q  <= sh_q; rb_q <= RB_DHI; end
                default: begin hi_q  <= sh_q; rb_q <= RB_DONE; end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_w) begin
              bitcnt_q <= '0;
              sda_oe   <= 1'b0;
              if (rb_q == RB_DONE) begin
                wr_en_q <= 1'b1;
                st_q    <= ST_IDLE;
              end else if (go_tx_q) begin
                go_tx_q <= 1'b0;
                tx_q    <= bus_val[7:0];
                tx_hi_q <= 1'b0;
                sda_oe  <= ~bus_val[7];
                st_q    <= ST_TX;
              end else begin
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_w) begin
              if (bitcnt_q == 4'd7) begin
                st_q   <= ST_TACK;
                sda_oe <= 1'b0;
              end else begin
                tx_q     <= {tx_q[6:0], 1'b0};
                sda_oe   <= ~tx_q[6];
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise_w) begin
              mack_q <= !sda_f;
            end else if (scl_fall_w) begin
              if (mack_q && !tx_hi_q) begin
                tx_q     <= bus_val[15:8];
                tx_hi_q  <= 1'b1;
                bitcnt_q <= '0;
                sda_oe   <= ~bus_val[15];
                st_q     <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a low supply-valid input forces idle with SDA released
  a_r8_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st_q == ST_IDLE && !sda_oe));
  // R6: a start condition always restarts address reception
  a_r6_start_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && start_w) |=> (st_q == ST_RX && bitcnt_q == 4'd0));
  // R3: a register write only follows the clock fall that ends an acknowledge
  a_r3_commit_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> $past(scl_fall_w));
  // R2: SDA is released while the block stays idle
  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !sda_oe);
  // R1: an acknowledge is held while SCL is high
  a_r1_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK && scl_f && $past(st_q) == ST_ACK) |-> sda_oe);
endmodule

// File: tb/tb_smb_word_slave.sv
module tb_smb_word_slave;
  localparam int NREG = 4;
  localparam int Q    = 16;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0;
  logic sda_oe, sda_bus;
  logic [1:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [15:0] model [NREG];
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  smb_word_slave #(.NUM_REGS(NREG), .FILT_LEN(4)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .scl_i(m_scl),
    .sda_i(sda_bus), .sda_oe(sda_oe), .rd_idx(rd_idx), .rd_data(rd_data));

  function automatic logic [15:0] exp_read(input logic [7:0] c);
    if (c == 8'hFE) return 16'h0040;
    if (c == 8'hFF) return 16'h0008;
    if (c < NREG)   return model[c[1:0]];
    return 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
    if (glitch) begin
      m_scl = 1'b0; tick(2); m_scl = 1'b1; glitch = 1'b0;
    end
    seen = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  task automatic write_word(input logic [6:0] a, input logic [7:0] c,
                            input logic [15:0] d, output logic [3:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[0]);
    send_byte(c, acks[1]);
    send_byte(d[7:0], acks[2]);
    send_byte(d[15:8], acks[3]);
    bus_stop();
  endtask

  task automatic read_word(input logic [7:0] c, output logic [15:0] d, output logic [2:0] acks);
    bus_start();
    send_byte(8'h12, acks[0]);
    send_byte(c, acks[1]);
    bus_start();
    send_byte(8'h13, acks[2]);
    recv_byte(1'b1, d[7:0]);
    recv_byte(1'b0, d[15:8]);
    bus_stop();
  endtask

  task automatic peek(input int i, output logic [15:0] d);
    rd_idx = 2'(i); tick(1); d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, pv;
    logic [3:0]  wa;
    logic [2:0]  ra;
    logic [7:0]  b;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    tick(5); rst_n = 1'b1; tick(5);

    // R12 / R2: reset state
    chk(sda_oe == 1'b0, "R2 reset release", {15'b0, sda_oe}, 16'h0);
    for (int i = 0; i < NREG; i++) begin
      peek(i, d);
      chk(d == 16'h0, "R12 reset reg", d, 16'h0);
    end

    // R3 / R7: directed write then parallel and bus read-back
    write_word(7'h09, 8'h01, 16'hA55A, wa);
    model[1] = 16'hA55A;
    chk(wa == 4'hF, "R1 R3 write acks", {12'b0, wa}, 16'hF);
    peek(1, d);
    chk(d == 16'hA55A, "R3 R7 parallel value", d, 16'hA55A);
    read_word(8'h01, d, ra);
    chk(ra == 3'h7 && d == 16'hA55A, "R4 read word", d, 16'hA55A);

    // R1: wrong address is not acknowledged and changes nothing
    write_word(7'h0A, 8'h01, 16'h1234, wa);
    chk(wa[0] == 1'b0, "R1 wrong addr nack", {12'b0, wa}, 16'h0);
    peek(1, d);
    chk(d == 16'hA55A, "R1 wrong addr no write", d, 16'hA55A);

    // R5: identification words, and writes to them ignored
    read_word(8'hFE, d, ra);
    chk(d == 16'h0040, "R5 mfr word", d, 16'h0040);
    write_word(7'h09, 8'hFF, 16'hFFFF, wa);
    read_word(8'hFF, d, ra);
    chk(d == 16'h0008, "R5 dev word after write", d, 16'h0008);

    // R11: unused command
    write_word(7'h09, 8'h20, 16'hBEEF, wa);
    read_word(8'h20, d, ra);
    chk(d == 16'h0000, "R11 unused cmd", d, 16'h0000);

    // R6: stop after the low byte leaves the register alone
    bus_start();
    send_byte(8'h12, wa[0]); send_byte(8'h02, wa[1]); send_byte(8'h77, wa[2]);
    bus_stop();
    peek(2, d);
    chk(d == 16'h0000, "R6 early stop no write", d, 16'h0000);

    // R8: supply low ignores the bus, then recovery
    supply_ok = 1'b0;
    write_word(7'h09, 8'h03, 16'hC3C3, wa);
    chk(wa == 4'h0, "R8 no ack when off", {12'b0, wa}, 16'h0);
    peek(3, d);
    chk(d == 16'h0000, "R8 no write when off", d, 16'h0000);
    supply_ok = 1'b1; tick(4);
    write_word(7'h09, 8'h03, 16'hC3C3, wa);
    model[3] = 16'hC3C3;
    peek(3, d);
    chk(d == 16'hC3C3, "R8 resumes", d, 16'hC3C3);

    // R9: NACK after low byte, further clocks see a released line
    bus_start();
    send_byte(8'h12, wa[0]); send_byte(8'h03, wa[1]);
    bus_start();
    send_byte(8'h13, wa[2]);
    recv_byte(1'b0, b);
    chk(b == 8'hC3, "R9 low byte", {8'b0, b}, 16'h00C3);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R9 released after nack", {8'b0, b}, 16'h00FF);
    bus_stop();

    // R10: short SCL glitch inside a data bit
    bus_start();
    send_byte(8'h12, wa[0]); send_byte(8'h00, wa[1]);
    glitch = 1'b1;
    send_byte(8'h96, wa[2]); send_byte(8'h69, wa[3]);
    bus_stop();
    model[0] = 16'h6996;
    peek(0, d);
    chk(d == 16'h6996, "R10 glitch ignored", d, 16'h6996);

    // Random traffic: R3 R4 R7
    for (int n = 0; n < 14; n++) begin
      int r;
      logic [7:0]  c;
      logic [15:0] v;
      r = int'($urandom % 6);
      c = (r < NREG) ? 8'(r) : ((r == 4) ? 8'hFE : 8'h31);
      v = 16'($urandom);
      write_word(7'h09, c, v, wa);
      if (c < NREG) model[c[1:0]] = v;
      chk(wa == 4'hF, "R3 random acks", {12'b0, wa}, 16'hF);
      r = int'($urandom % 6);
      c = (r < NREG) ? 8'(r) : ((r == 4) ? 8'hFF : 8'h31);
      read_word(c, d, ra);
      chk(d == exp_read(c), "R4 R7 random read", d, exp_read(c));
      chk(sda_oe == 1'b0, "R2 idle release", {15'b0, sda_oe}, 16'h0);
      if (c < NREG) begin
        peek(int'(c), pv);
        chk(pv == model[c[1:0]], "R3 random parallel", pv, model[c[1:0]]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule